// File: doc/BRIEF.md
# Fractional PLL Retune Sequencer

This block retunes a fractional-N PLL to a new output frequency without any software stepping. A caller places a target frequency in hertz on `rate_hz_i` and pulses `start_i`. The block first works out the PLL's integer and 24-bit fractional multiplier fields. A serial long division by one million produces both fields in a single pass. The block then acts as the only master on a simple register bus and performs the retune sequence in order: put the PLL in standby, poll until lock is lost, write the divider, fraction, integer and spread registers, release the PLL into normal mode, and poll until lock returns.

Each lock poll reads the status register again after a fixed gap. It gives up once a cycle limit has passed since the poll began. Both the gap and the limit are parameters counted in clock cycles. At the end the block pulses `done_o` and updates `rate_out_o` with the frequency it achieved, or it pulses `err_o`. A start strobe with a zero rate gets an immediate error and causes no bus traffic.

States: IDLE waits for a start. CALC runs the divider. STBY_WR, DIV_WR, FRAC_WR, INT_WR, SPRD_WR and NORM_WR each perform one register write. DROP_RD and DROP_WAIT make up the lock-loss poll. LOCK_RD and LOCK_WAIT make up the relock poll. DONE and FAIL each last one cycle and return to IDLE.

Transitions:
- IDLE to CALC on a start with a non-zero rate.
- IDLE to FAIL on a start with a zero rate.
- CALC to STBY_WR when the quotient is ready.
- Each write state to the next state on bus acknowledge.
- DROP_RD to DIV_WR when the lock bit reads 0.
- LOCK_RD to DONE when the lock bit reads 1.
- A poll read state to FAIL when the condition is unmet and the limit has been reached.
- A poll read state to its wait state otherwise.
- A wait state back to its read state when the gap ends.

Top module: `pll_retune_seq`

## Requirements
- R1: The integer field is the low 8 bits of floor(rate/1,000,000). The fraction field is floor((rate mod 1,000,000)·2^24/1,000,000), 24 bits wide.
- R2: The first bus transaction after an accepted start is a write to the mode register (address 0x00) with data 0x0001_0000. That value sets the run write-enable (bit 16) and leaves the run bit (bit 0) at 0.
- R3: After standby, the block reads the status register (address 0x28) until bit 4 (lock) reads 0. Consecutive poll reads complete at least POLL_GAP cycles apart.
- R4: The block then writes four registers in this order:
  - the divider register (0x08) with 0x0111_0211: post-divider 1 = 1 in bits 3:0, post-divider 2 = 1 in bits 7:4, reference divider = 2 in bits 9:8, and write-enables at bits 16, 20 and 24;
  - the fraction register (0x10) with the fraction shifted left by 8;
  - the integer register (0x18) with the integer in bits 23:16 and 0xFF in bits 7:0;
  - the spread register (0x20) with 0x16.
- R5: Next the block writes the mode register with 0x0015_0001, which sets the write-enables at bits 20, 18 and 16 and the run bit. It then polls status until bit 4 reads 1 and pulses `done_o` for one cycle.
- R6: If a poll condition is still unmet when POLL_LIMIT cycles have passed since the poll began, the block pulses `err_o` and makes no further bus transactions. `done_o` does not pulse.
- R7: A start with rate 0 raises `err_o` in the next cycle and causes no bus transaction.
- R8: `busy_o` is high from the cycle after an accepted start up to and including the cycle of `done_o` or `err_o`, and low otherwise. `done_o` and `err_o` never rise together. A bus request occurs only while busy.
- R9: A start strobe received while busy is ignored. The register values written come from the rate that was accepted.
- R10: `rate_out_o` becomes 12,000,000 × the integer field in the cycle `done_o` rises. That value is 24 MHz / 2 × integer / (1 × 1). It holds until the next `done_o`, through errors included.
- R11: A bus request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| rate_hz_i | input | 32 | Requested output frequency in Hz |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| rate_out_o | output | 32 | Achieved output frequency in Hz |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Register byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge (read data valid) |
| bus_rdata_i | input | 32 | Read data |

## Verification
The hardest paths to reach are the two poll timeouts. A healthy PLL never produces them, and the relock timeout only appears after all six writes have been accepted. The bench's register bank model makes the lock bit respond to the run-bit writes after configurable delays. One run holds lock high forever, so the lock-loss poll times out. Another run lets lock drop but never return, so the relock poll times out. A deliberate start strobe issued while busy checks that the accepted rate is kept.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CALC, S_STBY_WR, S_DROP_RD, S_DROP_WAIT,
        S_DIV_WR, S_FRAC_WR, S_INT_WR, S_SPRD_WR, S_NORM_WR,
        S_LOCK_RD, S_LOCK_WAIT, S_DONE, S_FAIL
    } seq_state_e;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIV    = 8'h08;
    localparam logic [ADDR_W-1:0] A_FRAC   = 8'h10;
    localparam logic [ADDR_W-1:0] A_INT    = 8'h18;
    localparam logic [ADDR_W-1:0] A_SPREAD = 8'h20;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h28;

    localparam int MODE_RUN_BIT  = 0;
    localparam int MODE_RUN_WEN  = 16;
    localparam int MODE_SSEN_WEN = 18;
    localparam int MODE_DSPR_WEN = 20;

    localparam int DIV_PD1_LSB = 0;
    localparam int DIV_PD2_LSB = 4;
    localparam int DIV_REF_LSB = 8;
    localparam int DIV_PD1_WEN = 16;
    localparam int DIV_PD2_WEN = 20;
    localparam int DIV_REF_WEN = 24;

    localparam int FRAC_LSB      = 8;
    localparam int INT_LSB       = 16;
    localparam int STAT_LOCK_BIT = 4;

    localparam int REFDIV   = 2;
    localparam int POSTDIV1 = 1;
    localparam int POSTDIV2 = 1;
    localparam logic [7:0] INT_LOW_BYTE = 8'hFF;
    localparam logic [7:0] SPREAD_VAL   = 8'h16;

endpackage

// File: rtl/serial_const_div.sv
module serial_const_div #(
    parameter int DIVIDEND_W = 56,
    parameter int DIVISOR    = 1000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [DIVIDEND_W-1:0] dividend_i,
    output logic                  done_o,
    output logic [DIVIDEND_W-1:0] quot_o
);
    localparam int REM_W = $clog2(DIVISOR) + 1;
    localparam int CNT_W = $clog2(DIVIDEND_W + 1);

    logic [DIVIDEND_W-1:0] dvd_q;
    logic [DIVIDEND_W-1:0] quot_q;
    logic [REM_W-1:0]      rem_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  run_q;
    logic                  done_q;
    logic [REM_W:0]        trial;
    logic                  fits;

    always_comb begin
        trial = {rem_q, dvd_q[DIVIDEND_W-1]};
        fits  = (trial >= (REM_W+1)'(DIVISOR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            quot_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                dvd_q  <= dividend_i;
                quot_q <= '0;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(DIVIDEND_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                dvd_q  <= {dvd_q[DIVIDEND_W-2:0], 1'b0};
                quot_q <= {quot_q[DIVIDEND_W-2:0], fits};
                rem_q  <= fits ? REM_W'(trial - (REM_W+1)'(DIVISOR)) : trial[REM_W-1:0];
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = quot_q;
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int GAP   = 12500,
    parameter int LIMIT = 31250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic gap_load_i,
    output logic gap_done_o,
    output logic limit_o
);
    localparam int GAP_W = $clog2(GAP + 1);
    localparam int LIM_W = $clog2(LIMIT + 1);

    logic [GAP_W-1:0] gap_q;
    logic [LIM_W-1:0] elapsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            elapsed_q <= '0;
        end else begin
            if (clr_i)
                elapsed_q <= '0;
            else if (elapsed_q != LIM_W'(LIMIT))
                elapsed_q <= elapsed_q + 1'b1;

            if (gap_load_i)
                gap_q <= GAP_W'(GAP);
            else if (gap_q != '0)
                gap_q <= gap_q - 1'b1;
        end
    end

    assign gap_done_o = (gap_q == '0);
    assign limit_o    = (elapsed_q == LIM_W'(LIMIT));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int RATE_W     = 32,
    parameter int FRAC_W     = 24,
    parameter int INT_W      = 8,
    parameter int REF_HZ     = 24000000,
    parameter int MHZ        = 1000000,
    parameter int POLL_GAP   = 12500,
    parameter int POLL_LIMIT = 31250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_hz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [RATE_W-1:0] rate_out_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    localparam int DVD_W   = RATE_W + FRAC_W;
    localparam int STEP_HZ = REF_HZ / REFDIV / (POSTDIV1 * POSTDIV2);

    localparam logic [DATA_W-1:0] W_STANDBY = DATA_W'(1) << MODE_RUN_WEN;
    localparam logic [DATA_W-1:0] W_NORMAL  = (DATA_W'(1) << MODE_DSPR_WEN) |
                                              (DATA_W'(1) << MODE_SSEN_WEN) |
                                              (DATA_W'(1) << MODE_RUN_WEN)  |
                                              (DATA_W'(1) << MODE_RUN_BIT);
    localparam logic [DATA_W-1:0] W_DIV     = (DATA_W'(1) << DIV_PD1_WEN) |
                                              (DATA_W'(1) << DIV_PD2_WEN) |
                                              (DATA_W'(1) << DIV_REF_WEN) |
                                              (DATA_W'(POSTDIV1) << DIV_PD1_LSB) |
                                              (DATA_W'(POSTDIV2) << DIV_PD2_LSB) |
                                              (DATA_W'(REFDIV)   << DIV_REF_LSB);

    seq_state_e        state_q, state_d;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [RATE_W-1:0] rate_out_q;
    logic              div_start, div_done;
    logic [DVD_W-1:0]  quot;
    logic              lock_seen;
    logic              tmr_clr, gap_load, gap_done, limit_hit;

    assign div_start = (state_q == S_IDLE) && start_i && (rate_hz_i != '0);
    assign lock_seen = bus_rdata_i[STAT_LOCK_BIT];
    assign tmr_clr   = bus_ack_i && ((state_q == S_STBY_WR) || (state_q == S_NORM_WR));
    assign gap_load  = bus_ack_i && !limit_hit &&
                       (((state_q == S_DROP_RD) && lock_seen) ||
                        ((state_q == S_LOCK_RD) && !lock_seen));

    serial_const_div #(
        .DIVIDEND_W (DVD_W),
        .DIVISOR    (MHZ)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i ({rate_hz_i, {FRAC_W{1'b0}}}),
        .done_o     (div_done),
        .quot_o     (quot)
    );

    poll_timer #(
        .GAP        (POLL_GAP),
        .LIMIT      (POLL_LIMIT)
    ) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tmr_clr),
        .gap_load_i (gap_load),
        .gap_done_o (gap_done),
        .limit_o    (limit_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Multiplier fields and achieved rate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q      <= '0;
            frac_q     <= '0;
            rate_out_q <= '0;
        end else begin
            if (div_done) begin
                int_q  <= quot[FRAC_W +: INT_W];
                frac_q <= quot[FRAC_W-1:0];
            end
            if ((state_q == S_LOCK_RD) && bus_ack_i && lock_seen)
                rate_out_q <= RATE_W'(STEP_HZ) * RATE_W'(int_q);
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_i) state_d = (rate_hz_i == '0) ? S_FAIL : S_CALC;
            S_CALC:      if (div_done) state_d = S_STBY_WR;
            S_STBY_WR:   if (bus_ack_i) state_d = S_DROP_RD;
            S_DROP_RD:
                if (bus_ack_i) begin
                    if (!lock_seen)     state_d = S_DIV_WR;
                    else if (limit_hit) state_d = S_FAIL;
                    else                state_d = S_DROP_WAIT;
                end
            S_DROP_WAIT: if (gap_done) state_d = S_DROP_RD;
            S_DIV_WR:    if (bus_ack_i) state_d = S_FRAC_WR;
            S_FRAC_WR:   if (bus_ack_i) state_d = S_INT_WR;
            S_INT_WR:    if (bus_ack_i) state_d = S_SPRD_WR;
            S_SPRD_WR:   if (bus_ack_i) state_d = S_NORM_WR;
            S_NORM_WR:   if (bus_ack_i) state_d = S_LOCK_RD;
            S_LOCK_RD:
                if (bus_ack_i) begin
                    if (lock_seen)      state_d = S_DONE;
                    else if (limit_hit) state_d = S_FAIL;
                    else                state_d = S_LOCK_WAIT;
                end
            S_LOCK_WAIT: if (gap_done) state_d = S_LOCK_RD;
            S_DONE:      state_d = S_IDLE;
            S_FAIL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        done_o      = 1'b0;
        err_o       = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (state_q)
            S_STBY_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_MODE; bus_wdata_o = W_STANDBY;
            end
            S_DROP_RD, S_LOCK_RD: begin
                bus_req_o = 1'b1; bus_addr_o = A_STAT;
            end
            S_DIV_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_DIV; bus_wdata_o = W_DIV;
            end
            S_FRAC_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_FRAC; bus_wdata_o = DATA_W'(frac_q) << FRAC_LSB;
            end
            S_INT_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_INT;
                bus_wdata_o = (DATA_W'(int_q) << INT_LSB) | DATA_W'(INT_LOW_BYTE);
            end
            S_SPRD_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_SPREAD; bus_wdata_o = DATA_W'(SPREAD_VAL);
            end
            S_NORM_WR: begin
                bus_req_o = 1'b1; bus_we_o = 1'b1;
                bus_addr_o = A_MODE; bus_wdata_o = W_NORMAL;
            end
            S_DONE:  done_o = 1'b1;
            S_FAIL:  err_o  = 1'b1;
            default: ;
        endcase
    end

    assign rate_out_o = rate_out_q;
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] rate_hz_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [31:0] rate_out_o,
    input logic        bus_req_o,
    input logic        bus_we_o,
    input logic [7:0]  bus_addr_o,
    input logic [31:0] bus_wdata_o,
    input logic        bus_ack_i,
    input logic [31:0] bus_rdata_i
);
    p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                      $stable(bus_we_o) && $stable(bus_wdata_o)));

    p_zero_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (rate_hz_i == 32'd0)) |=> (err_o && !bus_req_o));

    p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !busy_o);

    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o);

    p_rate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_out_o) |-> done_o);

    // R6: once an error ends the sequence, the bus stays quiet next cycle
    p_quiet_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !bus_req_o);
endmodule

bind pll_retune_seq pll_retune_seq_chk chk_i (.*);

// File: tb/pll_retune_seq_tb_top.sv
module pll_retune_seq_tb_top;
    localparam int GAP    = 8;
    localparam int LIMIT  = 200;
    localparam int DROP   = 20;
    localparam int RELOCK = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] rate_hz_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] rate_out_o;
    logic        bus_req_o, bus_we_o;
    logic [7:0]  bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic        bus_ack_i;
    logic [31:0] bus_rdata_i;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int lock_mode = 0;
    logic lock_bit;
    logic exp_busy;
    logic [7:0]  wr_addr_q[$];
    logic [31:0] wr_data_q[$];
    int          rd_time_q[$];

    always #4 clk = ~clk;

    pll_retune_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_hz_i(rate_hz_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rate_out_o(rate_out_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i));

    assign bus_rdata_i = {27'd0, lock_bit, 4'd0};

    // Register bank and PLL lock model
    int drop_cnt = 0;
    int relock_cnt = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            bus_ack_i <= 1'b0;
            lock_bit  <= 1'b1;
        end else begin
            if (drop_cnt > 0) begin
                drop_cnt = drop_cnt - 1;
                if (drop_cnt == 0) lock_bit <= 1'b0;
            end
            if (relock_cnt > 0) begin
                relock_cnt = relock_cnt - 1;
                if (relock_cnt == 0) lock_bit <= 1'b1;
            end
            if (bus_req_o && bus_ack_i) begin
                bus_ack_i <= 1'b0;
                if (bus_we_o) begin
                    wr_addr_q.push_back(bus_addr_o);
                    wr_data_q.push_back(bus_wdata_o);
                    if (bus_addr_o == 8'h00 && !bus_wdata_o[0] && lock_mode != 1) drop_cnt = DROP;
                    if (bus_addr_o == 8'h00 && bus_wdata_o[0] && lock_mode != 2) relock_cnt = RELOCK;
                end else begin
                    rd_time_q.push_back(cyc);
                end
            end else begin
                bus_ack_i <= bus_req_o;
            end
        end
    end

    // Behavioural busy model, compared on every clock (R8)
    always @(posedge clk) begin
        if (!rst_n) exp_busy <= 1'b0;
        else if (!exp_busy && start_i) exp_busy <= 1'b1;
        else if (exp_busy && (done_o || err_o)) exp_busy <= 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy_o !== exp_busy) begin
                failures++;
                $display("FAIL R8 busy at cycle %0d: actual %b expected %b", cyc, busy_o, exp_busy);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [7:0] exp_int(input logic [31:0] r);
        longint q = longint'(r) / 1000000;
        return q[7:0];
    endfunction

    function automatic logic [23:0] exp_frac(input logic [31:0] r);
        longint m = (longint'(r) % 1000000) * 16777216 / 1000000;
        return m[23:0];
    endfunction

    task automatic run_seq(input logic [31:0] rate, input int mode, input bit intr,
                           output bit got_done, output bit got_err, output int waited);
        wr_addr_q.delete(); wr_data_q.delete(); rd_time_q.delete();
        lock_mode = mode;
        got_done = 0; got_err = 0; waited = 0;
        @(negedge clk); start_i = 1'b1; rate_hz_i = rate;
        @(negedge clk); start_i = 1'b0; rate_hz_i = 32'd0;
        for (int i = 0; i < 5000; i++) begin
            if (intr && i == 4) begin
                start_i = 1'b1; rate_hz_i = 32'd50_000_000;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin got_done = 1; break; end
            if (err_o) begin got_err = 1; break; end
            waited++;
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_success(input logic [31:0] rate, input bit gd, input bit ge);
        logic [31:0] exp_w[6];
        logic [7:0]  exp_a[6];
        exp_a = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h00};
        exp_w[0] = 32'h0001_0000;
        exp_w[1] = 32'h0111_0211;
        exp_w[2] = {exp_frac(rate), 8'h00};
        exp_w[3] = {8'h00, exp_int(rate), 16'h00FF};
        exp_w[4] = 32'h0000_0016;
        exp_w[5] = 32'h0015_0001;
        chk(gd && !ge, "R5 done pulse", {gd, ge}, 2);
        chk(wr_addr_q.size() == 6, "R4 write count", wr_addr_q.size(), 6);
        for (int k = 0; k < 6 && k < wr_addr_q.size(); k++) begin
            chk(wr_addr_q[k] == exp_a[k], "R4 write address", wr_addr_q[k], exp_a[k]);
            chk(wr_data_q[k] == exp_w[k], (k == 0) ? "R2 standby data" :
                (k == 2 || k == 3) ? "R1 field data" : "R4 write data", wr_data_q[k], exp_w[k]);
        end
        chk(rate_out_o == 32'(12000000 * int'(exp_int(rate))), "R10 achieved rate",
            rate_out_o, 12000000 * int'(exp_int(rate)));
        for (int k = 1; k < rd_time_q.size(); k++)
            chk(rd_time_q[k] - rd_time_q[k-1] >= GAP, "R3 poll gap",
                rd_time_q[k] - rd_time_q[k-1], GAP);
        chk(rd_time_q.size() >= 3, "R3 poll reads", rd_time_q.size(), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit gd, ge;
        int w;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !bus_req_o, "R8 reset state",
            {busy_o, done_o, err_o, bus_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_seq(32'd148_500_000, 0, 0, gd, ge, w);
        check_success(32'd148_500_000, gd, ge);
        chk(exp_frac(32'd148_500_000) == 24'h800000, "R1 half fraction", exp_frac(32'd148_500_000), 24'h800000);

        run_seq(32'd74_250_000, 0, 0, gd, ge, w);
        check_success(32'd74_250_000, gd, ge);

        run_seq(32'd25_175_000, 0, 0, gd, ge, w);
        check_success(32'd25_175_000, gd, ge);

        run_seq(32'd300_000_123, 0, 0, gd, ge, w);
        check_success(32'd300_000_123, gd, ge);

        // R9: second start while busy must not alter the programmed values
        run_seq(32'd108_000_000, 0, 1, gd, ge, w);
        check_success(32'd108_000_000, gd, ge);

        // R7: zero rate
        prev = rate_out_o;
        run_seq(32'd0, 0, 0, gd, ge, w);
        chk(ge && !gd && w == 0, "R7 immediate error", {gd, ge, 8'(w)}, 256);
        chk(wr_addr_q.size() == 0 && rd_time_q.size() == 0, "R7 no bus",
            wr_addr_q.size() + rd_time_q.size(), 0);

        // R6: lock never drops
        run_seq(32'd60_000_000, 1, 0, gd, ge, w);
        chk(ge && !gd, "R6 drop timeout error", {gd, ge}, 1);
        chk(wr_addr_q.size() == 1, "R6 only standby written", wr_addr_q.size(), 1);
        chk(w >= LIMIT, "R6 timeout not early", w, LIMIT);
        chk(rate_out_o == prev, "R10 rate held on error", rate_out_o, prev);

        // R6: lock never returns
        run_seq(32'd60_000_000, 2, 0, gd, ge, w);
        chk(ge && !gd, "R6 relock timeout error", {gd, ge}, 1);
        chk(wr_addr_q.size() == 6, "R6 all writes before relock", wr_addr_q.size(), 6);
        chk(rate_out_o == prev, "R10 rate held after relock error", rate_out_o, prev);

        // Recovery after failure
        run_seq(32'd200_999_999, 0, 0, gd, ge, w);
        check_success(32'd200_999_999, gd, ge);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule